// File: doc/BRIEF.md
# Ethernet MAC Interrupt Status Aggregator

This block gathers the event pulses produced around an Ethernet MAC into one sticky status register and folds them into a single interrupt line. Each event source owns one status bit. Software clears a bit by writing 1 to it. A per-bit enable mask decides which set bits reach the interrupt output. Three status bits are not set straight from a pulse. The runt-overflow bit follows the top bit of a counter of runt frames with a CRC error. The receive-status bit only fires when three receive enables are all on. The bus-error bit also latches the ID of the DMA queue that was active and freezes every DMA queue.

A three-state controller drives the DMA halt. In RUN the queues move. A bus abort moves it to HALT. Clearing the bus-error bit moves HALT to WAIT. In WAIT the queues stay frozen until software writes the restart command, which moves it back to RUN. A new abort while in WAIT returns the controller to HALT.

Software reaches the block through a small word-addressed register port. The read path is combinational. Reading the runt counter clears the counter.

Top module: `emac_irq_agg`

## Requirements
- R1: After the asynchronous reset, and after a cycle with `soft_rst` high, the status register, the enables, the runt counter and the latched queue ID read 0, `irq` is 0 and `dma_halt` is 0.
- R2: Status bits are sticky. A write to address 0 clears exactly the bits whose `wdata` bit is 1. Bits written with 0 keep their value.
- R3: An event pulse in the same cycle as a write-1-clear of its bit wins, and the bit reads 1 afterwards.
- R4: The event pulses set these status bits on the next clock edge: `ev_tx` bit 1, `ev_other` bit 2, `ev_timer` bit 4, `ev_phy` bit 5, `ev_mgmt` bit 6.
- R5: `ev_rx` sets status bit 0 only when enable bits 8, 9 and 10 (receive end-of-frame, end-of-buffer, header) are all 1. Otherwise it has no effect.
- R6: Each `ev_runt` pulse adds one to the RUNT_W-bit runt counter, which is read at address 2. The counter saturates at all ones.
- R7: Status bit 7 (runt overflow) is set in the same edge where the counter's most significant bit goes from 0 to 1.
- R8: A read of address 2 returns the count and clears it to 0 on that edge. A runt pulse in the same cycle makes the new count 1.
- R9: An `ev_abort` pulse sets status bit 3 and captures `ev_abort_qid`. The captured ID reads back in bits [QID_W-1:0] of address 3, and `dma_halt` appears in bit 16.
- R10: `dma_halt` goes to 1 on the edge after an abort. It stays 1 while bit 3 is set, and a restart write (address 3, `wdata[0]`=1) in that state is ignored. After bit 3 is cleared, `dma_halt` stays 1 until a restart write, and it drops on the edge of that write.
- R11: `irq` is 1 exactly when some status bit n is 1 and enable bit n (address 1, bits 7:0) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous soft reset |
| ev_runt | input | 1 | Runt frame with CRC error received |
| ev_mgmt | input | 1 | Management bus operation completed |
| ev_phy | input | 1 | PHY change-of-status event |
| ev_timer | input | 1 | General timer reached zero |
| ev_abort | input | 1 | MAC bus cycle ended abnormally |
| ev_abort_qid | input | QID_W | DMA queue active at the abort |
| ev_tx | input | 1 | Transmit status posted |
| ev_rx | input | 1 | Receive status posted |
| ev_other | input | 1 | Any other status present |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 status, 1 enable, 2 runt count, 3 bus master |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational on addr |
| irq | output | 1 | Interrupt output |
| dma_halt | output | 1 | Freeze for all DMA queues |

## Verification
The assertions check four things on every cycle. An event always beats a same-cycle clear. A receive pulse with the gate shut never raises bit 0. The runt-overflow bit follows a rising counter MSB. DMA stays halted whenever the bus-error bit is set, and a restart during that time changes nothing. Some behaviour only the bench scenarios can show. That covers how the enable mask and the receive gate combine over many patterns, counter saturation and clear-on-read, and the full abort, clear and restart sequence with its exact cycle timing. It also covers the returned queue ID and the clearing effect of a soft reset.

// File: rtl/emac_irq_pkg.sv
package emac_irq_pkg;
    localparam int ST_W    = 8;
    localparam int EN_W    = 11;
    localparam int B_RX    = 0;
    localparam int B_TX    = 1;
    localparam int B_OTHER = 2;
    localparam int B_BERR  = 3;
    localparam int B_TMO   = 4;
    localparam int B_PHY   = 5;
    localparam int B_MGMT  = 6;
    localparam int B_RUNT  = 7;
    localparam int E_GATE0 = 8;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_WAIT = 2'd2
    } halt_st_e;
endpackage

// File: rtl/emac_runt_cnt.sv
module emac_runt_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic         inc,
    input  logic         rd_clr,
    output logic [W-1:0] cnt,
    output logic         msb_rise
);
    localparam logic [W-1:0] MAXV   = '1;
    localparam logic [W-1:0] BELOW  = MAXV >> 1;

    logic [W-1:0] cnt_d;

    always_comb begin
        if (rd_clr)
            cnt_d = inc ? W'(1) : '0;
        else if (inc && cnt != MAXV)
            cnt_d = cnt + W'(1);
        else
            cnt_d = cnt;
    end

    assign msb_rise = inc && !rd_clr && (cnt == BELOW);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (soft_rst) cnt <= '0;
        else               cnt <= cnt_d;
    end

    // R8: clear on read
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !inc && !soft_rst) |=> (cnt == '0));
    // R6: saturation
    a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAXV && !rd_clr && !soft_rst) |=> (cnt == MAXV));
endmodule

// File: rtl/emac_irq_status.sv
module emac_irq_status #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] status
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          status[i] <= 1'b0;
            else if (soft_rst)   status[i] <= 1'b0;
            else if (set_vec[i]) status[i] <= 1'b1;
            else if (clr_vec[i]) status[i] <= 1'b0;
        end

        // R3: event wins over a same-cycle clear
        a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (set_vec[i] && clr_vec[i] && !soft_rst) |=> status[i]);
        // R2: bit stays put without set, clear or soft reset
        a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_vec[i] && !clr_vec[i] && !soft_rst) |=> $stable(status[i]));
    end
endmodule

// File: rtl/emac_dma_halt_fsm.sv
module emac_dma_halt_fsm
    import emac_irq_pkg::*;
#(
    parameter int QID_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             abort,
    input  logic [QID_W-1:0] abort_qid,
    input  logic             berr_flag,
    input  logic             restart,
    output logic             halt,
    output logic [QID_W-1:0] qid
);
    halt_st_e state, state_d;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_RUN:  if (abort) state_d = ST_HALT;
            ST_HALT: if (!berr_flag && !abort) state_d = ST_WAIT;
            ST_WAIT: begin
                if (abort)        state_d = ST_HALT;
                else if (restart) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state <= ST_RUN;
        else if (soft_rst) state <= ST_RUN;
        else               state <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        qid <= '0;
        else if (soft_rst) qid <= '0;
        else if (abort)    qid <= abort_qid;
    end

    always_comb begin
        halt = (state != ST_RUN);
    end

    // R10: restart ignored while the bus-error bit is set
    a_r10_restart_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (berr_flag && restart && !soft_rst) |=> halt);
    // R10: abort always halts
    a_r10_abort_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !soft_rst) |=> halt);
endmodule

// File: rtl/emac_irq_agg.sv
module emac_irq_agg
    import emac_irq_pkg::*;
#(
    parameter int RUNT_W = 4,
    parameter int QID_W  = 3,
    parameter int DW     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             ev_runt,
    input  logic             ev_mgmt,
    input  logic             ev_phy,
    input  logic             ev_timer,
    input  logic             ev_abort,
    input  logic [QID_W-1:0] ev_abort_qid,
    input  logic             ev_tx,
    input  logic             ev_rx,
    input  logic             ev_other,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             irq,
    output logic             dma_halt
);
    localparam int HALT_POS = 16;

    logic [EN_W-1:0]   en_q;
    logic [ST_W-1:0]   status, set_vec, clr_vec;
    logic [RUNT_W-1:0] runt_cnt;
    logic              runt_rise, rx_gate, restart, cnt_rd;
    logic [QID_W-1:0]  qid;
    logic              unused_wdata;

    assign unused_wdata = ^wdata;
    assign rx_gate      = &en_q[EN_W-1:E_GATE0];
    assign restart      = wr_en && (addr == 2'd3) && wdata[0];
    assign cnt_rd       = rd_en && (addr == 2'd2);

    always_comb begin
        set_vec         = '0;
        set_vec[B_RX]   = ev_rx && rx_gate;
        set_vec[B_TX]   = ev_tx;
        set_vec[B_OTHER]= ev_other;
        set_vec[B_BERR] = ev_abort;
        set_vec[B_TMO]  = ev_timer;
        set_vec[B_PHY]  = ev_phy;
        set_vec[B_MGMT] = ev_mgmt;
        set_vec[B_RUNT] = runt_rise;
        clr_vec = (wr_en && addr == 2'd0) ? wdata[ST_W-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        en_q <= '0;
        else if (soft_rst)                 en_q <= '0;
        else if (wr_en && addr == 2'd1)    en_q <= wdata[EN_W-1:0];
    end

    emac_runt_cnt #(.W(RUNT_W)) u_runt (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .inc(ev_runt), .rd_clr(cnt_rd),
        .cnt(runt_cnt), .msb_rise(runt_rise)
    );

    emac_irq_status #(.N(ST_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .set_vec(set_vec), .clr_vec(clr_vec), .status(status)
    );

    emac_dma_halt_fsm #(.QID_W(QID_W)) u_halt (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .abort(ev_abort), .abort_qid(ev_abort_qid),
        .berr_flag(status[B_BERR]), .restart(restart),
        .halt(dma_halt), .qid(qid)
    );

    always_comb begin
        rdata = '0;
        unique case (addr)
            2'd0: rdata[ST_W-1:0]   = status;
            2'd1: rdata[EN_W-1:0]   = en_q;
            2'd2: rdata[RUNT_W-1:0] = runt_cnt;
            2'd3: begin
                rdata[QID_W-1:0] = qid;
                rdata[HALT_POS]  = dma_halt;
            end
            default: rdata = '0;
        endcase
    end

    assign irq = |(status & en_q[ST_W-1:0]);

    // R7: overflow bit follows the rising counter MSB
    a_r7_runt_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(runt_cnt[RUNT_W-1]) |-> status[B_RUNT]);
    // R5: receive pulse with the gate shut never raises bit 0
    a_r5_rx_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx && !rx_gate && !status[B_RX]) |=> !status[B_RX]);
    // R10: halted whenever the bus-error bit is set
    a_r10_halt_on_berr: assert property (@(posedge clk) disable iff (!rst_n)
        status[B_BERR] |-> dma_halt);
endmodule

// File: tb/emac_irq_agg_bench.sv
module emac_irq_agg_bench;
    localparam int QW = 3;

    logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
    logic ev_runt = 0, ev_mgmt = 0, ev_phy = 0, ev_timer = 0, ev_abort = 0;
    logic [QW-1:0] ev_abort_qid = '0;
    logic ev_tx = 0, ev_rx = 0, ev_other = 0;
    logic wr_en = 0, rd_en = 0;
    logic [1:0] addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic irq, dma_halt;

    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    emac_irq_agg #(.RUNT_W(4), .QID_W(QW), .DW(32)) u_emac_irq_agg (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .ev_runt(ev_runt), .ev_mgmt(ev_mgmt), .ev_phy(ev_phy),
        .ev_timer(ev_timer), .ev_abort(ev_abort), .ev_abort_qid(ev_abort_qid),
        .ev_tx(ev_tx), .ev_rx(ev_rx), .ev_other(ev_other),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq), .dma_halt(dma_halt)
    );

    // {gate[2:0], en[7:0], events[7:0] in status-bit order, expected status}
    localparam int NV = 9;
    localparam logic [26:0] VEC [NV] = '{
        {3'b111, 8'hFF, 8'h01, 8'h01},
        {3'b011, 8'hFF, 8'h01, 8'h00},
        {3'b101, 8'hFF, 8'h01, 8'h00},
        {3'b110, 8'hFF, 8'h01, 8'h00},
        {3'b000, 8'h00, 8'h02, 8'h02},
        {3'b000, 8'h10, 8'h10, 8'h10},
        {3'b000, 8'h40, 8'h20, 8'h20},
        {3'b000, 8'hFF, 8'h74, 8'h74},
        {3'b111, 8'h01, 8'h77, 8'h77}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1; addr = a; wdata = d;
        tick();
        wr_en = 0; wdata = '0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
        addr = a; rd_en = 1;
        #0.5 d = rdata;
        tick();
        rd_en = 0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #0.5 d = rdata;
    endtask

    task automatic set_events(input logic [7:0] m);
        ev_rx = m[0]; ev_tx = m[1]; ev_other = m[2]; ev_abort = m[3];
        ev_timer = m[4]; ev_phy = m[5]; ev_mgmt = m[6]; ev_runt = m[7];
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        tick();
        // R1 reset state
        peek(2'd0, d); check("R1 status after reset", d, 0);
        peek(2'd1, d); check("R1 enable after reset", d, 0);
        peek(2'd2, d); check("R1 runt after reset", d, 0);
        peek(2'd3, d); check("R1 bus master after reset", d, 0);
        check("R1 irq after reset", {31'd0, irq}, 0);
        check("R1 halt after reset", {31'd0, dma_halt}, 0);

        // R4 R5 R11 table walk
        for (int i = 0; i < NV; i++) begin
            reg_wr(2'd1, {21'd0, VEC[i][26:24], VEC[i][23:16]});
            reg_wr(2'd0, 32'hFF);
            set_events(VEC[i][15:8]);
            tick();
            set_events(8'h00);
            peek(2'd0, d);
            check("R4/R5 status vector", d, {24'd0, VEC[i][7:0]});
            check("R11 irq vector", {31'd0, irq}, {31'd0, |(VEC[i][7:0] & VEC[i][23:16])});
        end

        // R2 writing zeros does not clear, writing ones clears selected
        reg_wr(2'd0, 32'h00);
        peek(2'd0, d); check("R2 write zero keeps", d, 32'h77);
        reg_wr(2'd0, 32'h05);
        peek(2'd0, d); check("R2 partial clear", d, 32'h72);

        // R3 event beats same-cycle clear
        ev_mgmt = 1;
        reg_wr(2'd0, 32'h40);
        ev_mgmt = 0;
        peek(2'd0, d); check("R3 set wins over clear", d, 32'h72);
        reg_wr(2'd0, 32'hFF);

        // R6 R7 runt counting
        for (int k = 0; k < 7; k++) begin
            ev_runt = 1; tick(); ev_runt = 0;
        end
        peek(2'd0, d); check("R7 no overflow at 7", d, 0);
        peek(2'd2, d); check("R6 count 7", d, 7);
        ev_runt = 1; tick(); ev_runt = 0;
        peek(2'd0, d); check("R7 overflow at msb", d, 32'h80);
        for (int k = 0; k < 10; k++) begin
            ev_runt = 1; tick(); ev_runt = 0;
        end
        // R8 read returns count then clears
        reg_rd(2'd2, d); check("R6 saturated count", d, 15);
        peek(2'd2, d); check("R8 cleared after read", d, 0);
        peek(2'd0, d); check("R7 overflow sticky", d, 32'h80);
        ev_runt = 1;
        reg_rd(2'd2, d);
        ev_runt = 0;
        peek(2'd2, d); check("R8 read with runt gives 1", d, 1);
        reg_wr(2'd0, 32'hFF);

        // R9 R10 abort, halt, clear, restart
        ev_abort = 1; ev_abort_qid = 3'd5;
        tick();
        ev_abort = 0; ev_abort_qid = '0;
        check("R10 halt after abort", {31'd0, dma_halt}, 1);
        peek(2'd0, d); check("R9 bus error bit", d, 32'h08);
        peek(2'd3, d); check("R9 queue id and halt", d, 32'h0001_0005);
        reg_wr(2'd3, 32'h1);
        check("R10 restart ignored while error set", {31'd0, dma_halt}, 1);
        reg_wr(2'd0, 32'h08);
        tick();
        check("R10 halt holds after clear", {31'd0, dma_halt}, 1);
        tick();
        check("R10 still waiting for restart", {31'd0, dma_halt}, 1);
        reg_wr(2'd3, 32'h1);
        check("R10 restart releases", {31'd0, dma_halt}, 0);

        // R1 soft reset
        reg_wr(2'd1, 32'h7FF);
        ev_phy = 1; ev_abort = 1; ev_abort_qid = 3'd2;
        tick();
        ev_phy = 0; ev_abort = 0; ev_abort_qid = '0;
        check("R11 irq before soft reset", {31'd0, irq}, 1);
        soft_rst = 1; tick(); soft_rst = 0;
        peek(2'd0, d); check("R1 soft reset status", d, 0);
        peek(2'd1, d); check("R1 soft reset enable", d, 0);
        peek(2'd3, d); check("R1 soft reset bus master", d, 0);
        check("R1 soft reset irq", {31'd0, irq}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule